// File: doc/BRIEF.md
# Daisy-Chain Interrupt Acknowledge Controller

This block answers interrupt acknowledge cycles for a peripheral placed in a serial priority chain. Several internal sources are ranked in a fixed order. Index 0 has the highest priority. Each source has a pending input, an enable input and an in-service latch. The block drives an active-low request line toward the processor. It also drives a chain output that passes the upstream enable on to lower-priority devices, or blocks it.

An acknowledge cycle opens when the acknowledge strobe goes low. The block waits a configurable number of clocks so the priority chain can settle. It then looks for a falling read strobe. If the upstream chain input is high and an eligible source is waiting, the block claims the cycle. It latches the winning source as in service and, when vector response is on, places an 8-bit vector on the data bus until the read strobe returns high. A software command releases the highest-priority latch that is in service. All strobes are sampled on the block clock.

Top module: `daisy_ack_ctrl`

## Requirements
- R1: `int_n` is low exactly when `iei` is high and some source i has `src_req[i]` and `src_en[i]` set and no in-service latch at index i or lower (equal or higher priority) is set.
- R2: `ieo` is high exactly when `iei` is high, no in-service latch is set, and it is not the case that `intack_n` is low while some source has both request and enable set.
- R3: A claim happens at a clock edge only when all of these hold at that edge: `rd_n` is sampled low after being high at the previous edge, `intack_n` is low, `iei` is high, an eligible source exists (as in R1), and `intack_n` has been sampled low on at least SETTLE_CYC earlier consecutive edges. Without a claim, no latch is set and `data_oe` does not rise.
- R4: On a claim, the in-service latch of the lowest-index eligible source is set, effective from the next cycle.
- R5: After a claim with `vec_resp_en` high, `data_oe` is high from the next cycle until the first edge that samples `rd_n` or `intack_n` high. With `vec_resp_en` low, the latch is still set but `data_oe` stays low.
- R6: The driven vector is `vec_base`. When `vec_mod_en` is high at the claim, bits [2:0] are replaced by the winning source index.
- R7: With `rst_ius_cmd` high at an edge, only the lowest-index set in-service latch is cleared. A claim at the same edge still sets its own latch.
- R8: After reset, no latch is set, `data_oe` is low and `data_out` is 0.
- R9: The tri-stated bus is shown as `data_oe` low, and then `data_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | NSRC | Pending level per source, index 0 highest |
| src_en | input | NSRC | Interrupt enable per source |
| vec_base | input | 8 | Programmed interrupt vector |
| vec_resp_en | input | 1 | Drive the vector on a claimed acknowledge |
| vec_mod_en | input | 1 | Put the winner index in vector bits [2:0] |
| iei | input | 1 | Upstream chain enable |
| intack_n | input | 1 | Acknowledge strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| rst_ius_cmd | input | 1 | Release the highest-priority in-service latch |
| int_n | output | 1 | Interrupt request, active low |
| ieo | output | 1 | Downstream chain enable |
| data_out | output | 8 | Vector data |
| data_oe | output | 1 | Data bus drive enable |

## Verification
The hardest case to reach is a read strobe that falls inside the settle window. It is easy to reject, but it then has to be followed by a second falling edge in the same acknowledge that is accepted. Directed stimulus holds the acknowledge low, drops the read strobe one clock after it, raises the strobe again and drops it after the window ends. A nested sequence stacks two latches, with a lower source already in service when a higher one is claimed. It then checks that each release frees exactly one of them. A long random phase mixes all inputs, and the behavioural model is compared every cycle.

// File: rtl/daisy_pkg.sv
package daisy_pkg;
  localparam int VEC_W  = 8;
  localparam int CODE_W = 3;
  typedef logic [VEC_W-1:0] vec_t;
endpackage

// File: rtl/first_set.sv
module first_set #(
  parameter int N = 4
) (
  input  logic [N-1:0] vec,
  output logic [N-1:0] onehot,
  output logic         any
);
  always_comb begin
    onehot = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) onehot = N'(1) << i;
    end
    any = |vec;
  end
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int SETTLE_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic intack_n,
  output logic settled
);
  localparam int CW = (SETTLE_CYC > 0) ? $clog2(SETTLE_CYC + 1) : 1;
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYC);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (intack_n)            cnt_d = '0;
    else if (cnt_q == LIMIT) cnt_d = cnt_q;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign settled = (cnt_q == LIMIT);
endmodule

// File: rtl/vector_drive.sv
module vector_drive
  import daisy_pkg::*;
#(
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          claim,
  input  logic          release_bus,
  input  logic [IW-1:0] win_idx,
  input  vec_t          vec_base,
  input  logic          vec_resp_en,
  input  logic          vec_mod_en,
  output vec_t          data_out,
  output logic          data_oe
);
  localparam int CODE_BITS = (IW < CODE_W) ? IW : CODE_W;

  logic oe_q, oe_d;
  vec_t data_q, data_d, vec_sel;
  logic [CODE_W-1:0] code;

  always_comb begin
    code = '0;
    code[CODE_BITS-1:0] = win_idx[CODE_BITS-1:0];
    vec_sel = vec_base;
    if (vec_mod_en) vec_sel[CODE_W-1:0] = code;
  end

  always_comb begin
    oe_d   = oe_q;
    data_d = data_q;
    if (claim) begin
      oe_d   = vec_resp_en;
      data_d = vec_resp_en ? vec_sel : '0;
    end else if (release_bus) begin
      oe_d   = 1'b0;
      data_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q   <= 1'b0;
      data_q <= '0;
    end else begin
      oe_q   <= oe_d;
      data_q <= data_d;
    end
  end

  assign data_oe  = oe_q;
  assign data_out = data_q;
endmodule

// File: rtl/daisy_ack_ctrl.sv
module daisy_ack_ctrl
  import daisy_pkg::*;
#(
  parameter int NSRC       = 6,
  parameter int SETTLE_CYC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req,
  input  logic [NSRC-1:0] src_en,
  input  logic [7:0]      vec_base,
  input  logic            vec_resp_en,
  input  logic            vec_mod_en,
  input  logic            iei,
  input  logic            intack_n,
  input  logic            rd_n,
  input  logic            rst_ius_cmd,
  output logic            int_n,
  output logic            ieo,
  output logic [7:0]      data_out,
  output logic            data_oe
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0] ius_q, ius_d, blk, elig, win_oh, clr_oh, active;
  logic [IW-1:0]   win_idx;
  logic            win_any, clr_any, settled, rd_q, claim;

  // prefix OR: a source is blocked by any latch at its own or higher priority
  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_blk
      if (g == 0) begin : g_first
        assign blk[g] = ius_q[g];
      end else begin : g_rest
        assign blk[g] = blk[g-1] | ius_q[g];
      end
    end
  endgenerate

  assign active = src_req & src_en;
  assign elig   = active & ~blk;

  first_set #(.N(NSRC)) u_win (.vec(elig),  .onehot(win_oh), .any(win_any));
  first_set #(.N(NSRC)) u_clr (.vec(ius_q), .onehot(clr_oh), .any(clr_any));

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (win_oh[i]) win_idx = win_idx | IW'(i);
    end
  end

  settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .intack_n(intack_n), .settled(settled)
  );

  assign claim = settled & ~intack_n & ~rd_n & rd_q & iei & win_any;

  always_comb begin
    ius_d = ius_q;
    if (rst_ius_cmd && clr_any) ius_d = ius_d & ~clr_oh;
    if (claim)                  ius_d = ius_d | win_oh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ius_q <= '0;
      rd_q  <= 1'b1;
    end else begin
      ius_q <= ius_d;
      rd_q  <= rd_n;
    end
  end

  vector_drive #(.IW(IW)) u_vec (
    .clk(clk), .rst_n(rst_n), .claim(claim),
    .release_bus(rd_n | intack_n), .win_idx(win_idx),
    .vec_base(vec_base), .vec_resp_en(vec_resp_en), .vec_mod_en(vec_mod_en),
    .data_out(data_out), .data_oe(data_oe)
  );

  assign int_n = ~(iei & win_any);
  assign ieo   = iei & ~(|ius_q) & ~(~intack_n & (|active));
endmodule

// File: rtl/daisy_ack_ctrl_chk.sv
module daisy_ack_ctrl_chk #(
  parameter int NSRC = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            iei,
  input logic            intack_n,
  input logic            rst_ius_cmd,
  input logic            int_n,
  input logic            ieo,
  input logic [7:0]      data_out,
  input logic            data_oe,
  input logic [NSRC-1:0] ius_q,
  input logic            claim
);
  assert_no_req_without_iei_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !iei |-> int_n);

  assert_ieo_blocked_in_service_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|ius_q) |-> !ieo);

  assert_oe_only_in_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_oe) |-> $past(!intack_n));

  assert_claim_sets_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    claim |=> (ius_q != '0));

  assert_release_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ius_cmd && !claim && (ius_q != '0)) |=>
      ($countones(ius_q) + 1 == $countones($past(ius_q))));

  assert_idle_bus_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> (data_out == 8'h00));
endmodule

bind daisy_ack_ctrl daisy_ack_ctrl_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .iei(iei), .intack_n(intack_n),
  .rst_ius_cmd(rst_ius_cmd), .int_n(int_n), .ieo(ieo),
  .data_out(data_out), .data_oe(data_oe), .ius_q(ius_q), .claim(claim)
);

// File: tb/daisy_ack_ctrl_tb_top.sv
`timescale 1ns/1ps
module daisy_ack_ctrl_tb_top;
  localparam int NSRC   = 6;
  localparam int SETTLE = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] src_req = '0, src_en = '0;
  logic [7:0] vec_base = 8'hA5;
  logic vec_resp_en = 1'b1, vec_mod_en = 1'b0;
  logic iei = 1'b1, intack_n = 1'b1, rd_n = 1'b1, rst_ius_cmd = 1'b0;
  logic int_n, ieo, data_oe;
  logic [7:0] data_out;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // reference state
  logic [NSRC-1:0] m_ius;
  int m_cnt;
  bit m_rdq, m_oe;
  logic [7:0] m_data;

  always #2.5 clk = ~clk;

  daisy_ack_ctrl #(.NSRC(NSRC), .SETTLE_CYC(SETTLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_en(src_en),
    .vec_base(vec_base), .vec_resp_en(vec_resp_en), .vec_mod_en(vec_mod_en),
    .iei(iei), .intack_n(intack_n), .rd_n(rd_n), .rst_ius_cmd(rst_ius_cmd),
    .int_n(int_n), .ieo(ieo), .data_out(data_out), .data_oe(data_oe)
  );

  function automatic int winner();
    for (int i = 0; i < NSRC; i++) begin
      bit held = 0;
      for (int j = 0; j <= i; j++) if (m_ius[j]) held = 1;
      if (src_req[i] && src_en[i] && !held) return i;
    end
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ius = '0; m_cnt = 0; m_rdq = 1; m_oe = 0; m_data = 8'h00;
    end else begin
      int w;
      bit take;
      w = winner();
      take = (m_cnt >= SETTLE) && !intack_n && !rd_n && m_rdq && iei && (w >= 0);
      if (rst_ius_cmd) begin
        for (int i = 0; i < NSRC; i++)
          if (m_ius[i]) begin m_ius[i] = 1'b0; break; end
      end
      if (take) begin
        m_ius[w] = 1'b1;
        m_oe = vec_resp_en;
        if (!vec_resp_en) m_data = 8'h00;
        else if (vec_mod_en) m_data = {vec_base[7:3], 3'(w)};
        else m_data = vec_base;
      end else if (rd_n || intack_n) begin
        m_oe = 0; m_data = 8'h00;
      end
      m_cnt = intack_n ? 0 : ((m_cnt < SETTLE) ? m_cnt + 1 : m_cnt);
      m_rdq = rd_n;
    end
  end

  task automatic chk1(input string tag, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  task automatic compare();
    bit any_act = 0, eint_n, eieo;
    for (int i = 0; i < NSRC; i++) if (src_req[i] && src_en[i]) any_act = 1;
    eint_n = !(iei && winner() >= 0);
    eieo   = iei && (m_ius == '0) && !(!intack_n && any_act);
    chk1("R1/R4/R7 int_n", int_n, eint_n);
    chk1("R2/R4/R7 ieo", ieo, eieo);
    chk1("R3/R5 data_oe", data_oe, m_oe);
    n_vec++;
    if (data_out !== m_data) begin
      n_bad++;
      $display("FAIL R6/R9 data_out at %0t: actual %h expected %h", $time, data_out, m_data);
    end
  endtask

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #0.5;
      compare();
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    step(2);
    // R8: reset state
    n_vec++;
    if (data_oe !== 1'b0 || data_out !== 8'h00 || int_n !== 1'b1) begin
      n_bad++;
      $display("FAIL R8 reset: actual oe=%b data=%h int_n=%b expected 0 00 1", data_oe, data_out, int_n);
    end
    rst_n = 1'b1;
    step(2);
    // R1: requests from sources 2 and 4
    src_en = 6'b111111; src_req = 6'b010100; step(2);
    iei = 1'b0; step(2);                         // R1/R2 blocked upstream
    iei = 1'b1; step(1);
    // R3: read falls inside settle window, then later accepted
    intack_n = 1'b0; step(1);
    rd_n = 1'b0; step(2);
    rd_n = 1'b1; step(3);
    rd_n = 1'b0; step(3);                        // R4/R5: claim source 2
    rd_n = 1'b1; intack_n = 1'b1; step(2);
    // source 4 blocked by latch 2, source 0 wins over it
    src_req = 6'b010101; step(2);
    vec_mod_en = 1'b1; intack_n = 1'b0; step(4); // R6 status code
    rd_n = 1'b0; step(2);
    rd_n = 1'b1; intack_n = 1'b1; step(1);
    // R7: release highest latch, then the next
    src_req = 6'b010100;
    rst_ius_cmd = 1'b1; step(1);
    rst_ius_cmd = 1'b0; step(2);
    rst_ius_cmd = 1'b1; step(1);
    rst_ius_cmd = 1'b0; step(2);
    // R5: response disabled still sets latch
    vec_resp_en = 1'b0; intack_n = 1'b0; step(4);
    rd_n = 1'b0; step(2);
    rd_n = 1'b1; intack_n = 1'b1; vec_resp_en = 1'b1; step(1);
    // R3: iei low at read fall rejects
    rst_ius_cmd = 1'b1; step(1); rst_ius_cmd = 1'b0;
    intack_n = 1'b0; step(4); iei = 1'b0; rd_n = 1'b0; step(2);
    rd_n = 1'b1; intack_n = 1'b1; iei = 1'b1; step(2);
    // random phase
    for (int t = 0; t < 3000; t++) begin
      src_req = 6'($urandom); src_en = 6'($urandom);
      vec_base = 8'($urandom); vec_resp_en = ($urandom % 4) != 0;
      vec_mod_en = 1'($urandom); iei = ($urandom % 8) != 0;
      if ($urandom % 6 == 0) intack_n = ~intack_n;
      if ($urandom % 3 == 0) rd_n = ~rd_n;
      rst_ius_cmd = ($urandom % 10) == 0;
      step(1);
    end
    finish_run();
  end
endmodule